// File: doc/BRIEF.md
# Memory Region Attribute Register File

This block keeps one small attribute register for every 16 MB region of a 32-bit logical address space, 256 registers in all. Each register holds two flags. The first says whether accesses to the region may be cached. The second says whether the region may be prefetched. Software reaches the registers through a word-addressed register port. Cache and prefetch logic reach them through a lookup port, which takes a logical address and returns the two flags of the region that contains it in the same cycle.

The top address byte of a logical address selects the register. The sixteen lowest regions describe memories inside the processing core, so their registers are fixed at zero and software cannot change them. The register port gives a response one cycle after each request. That response carries the read data, and it flags bad offsets as an error.

Top module: `region_attr_regfile`

## Requirements
- R1: The lookup port selects register number `lk_addr[31:24]` and drives `lk_cacheable` and `lk_prefetch` from that register combinationally, in the same cycle.
- R2: In every register, bit 0 is the cacheable flag and bit 3 is the prefetchable flag. A read returns them at those positions, and the lookup outputs carry the same values.
- R3: A write stores only bits 0 and 3 of `reg_wdata`. Every other bit of a register always reads as zero.
- R4: Byte offset 4*n on the register port addresses register n, for n from 0 to 255.
- R5: Registers 0 to 15 always read as zero and give zero flags on lookup. A write to any of them changes nothing.
- R6: A valid write to register 16 or above updates both flags at the clock edge that accepts it. The lookup outputs show the new value from that edge onward.
- R7: Synchronous active-low reset clears every flag and the response outputs.
- R8: A request whose offset has bit 1 or bit 0 set gets `rsp_err` = 1 and read data zero. It writes nothing.
- R9: A request whose offset is 1024 or more (outside the 256-word window) gets `rsp_err` = 1 and read data zero. It writes nothing.
- R10: A request accepted at a clock edge raises `rsp_vld` for exactly the following cycle. A read returns the register value. A write returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_req | input | 1 | Register access request for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_off | input | 12 | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data, with reserved bits zero |
| rsp_err | output | 1 | Bad offset (misaligned or outside the window) |
| lk_addr | input | 32 | Logical address to classify |
| lk_cacheable | output | 1 | Cacheable flag of the region of `lk_addr` |
| lk_prefetch | output | 1 | Prefetchable flag of the region of `lk_addr` |

## Verification
Directed writes with all 32 data bits set separate the stored flags from the reserved bits that are dropped. The same writes aimed at registers 15 and 16 find the exact edge of the read-only range. Offsets with each low bit set, and offsets just past the last register, show which errors suppress the write. Random reads, writes and lookups follow, with the lookup address often placed on a region that was just written. A reference model checks them on every clock, which exposes a wrong index slice or a lookup that lags the write by a cycle.

// File: rtl/region_attr_pkg.sv
// Shared types and field positions for the region attribute register file.
// Assumes 32-bit register words with exactly two implemented flag bits.
package region_attr_pkg;
    localparam int REG_W     = 32;
    localparam int CACHE_POS = 0;
    localparam int PREF_POS  = 3;

    typedef struct packed {
        logic pref;
        logic cache;
    } attr_t;

    // Expand a flag pair into a register word, with reserved bits zero.
    function automatic logic [REG_W-1:0] attr_to_word(attr_t a);
        logic [REG_W-1:0] w;
        w = '0;
        w[CACHE_POS] = a.cache;
        w[PREF_POS]  = a.pref;
        return w;
    endfunction

    // Extract the implemented bits from a write word.
    function automatic attr_t word_to_attr(logic [REG_W-1:0] w);
        attr_t a;
        a.cache = w[CACHE_POS];
        a.pref  = w[PREF_POS];
        return a;
    endfunction
endpackage

// File: rtl/region_attr_decode.sv
// Offset decoder for the register port. It splits a byte offset into a word
// index and flags an offset that is misaligned or lies outside the window.
// Assumes OFF_W > IDX_W + 2, so bits exist above the window.
module region_attr_decode #(
    parameter int IDX_W = 8,
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0] off,
    output logic [IDX_W-1:0] idx,
    output logic             bad
);
    localparam int WIN_LSB = IDX_W + 2;

    // Word index from the offset, plus the error for misalignment or range.
    always_comb begin
        idx = off[WIN_LSB-1:2];
        bad = (|off[1:0]) | (|off[OFF_W-1:WIN_LSB]);
    end
endmodule

// File: rtl/region_attr_store.sv
// Flag storage: one attr_t per region. Entries below RO_COUNT are constant
// zero. Assumes at most one write per cycle, already checked for errors.
module region_attr_store
    import region_attr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int RO_COUNT = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  attr_t                  wr_attr,
    output attr_t [(1<<IDX_W)-1:0] table_q
);
    localparam int N_REG = 1 << IDX_W;
    localparam logic [IDX_W-1:0] RO_LIM = IDX_W'(RO_COUNT);

    for (genvar i = 0; i < N_REG; i++) begin : g_ent
        if (i < RO_COUNT) begin : g_ro
            // Fixed region: its flags stay zero.
            assign table_q[i] = '0;
        end else begin : g_rw
            attr_t ent_q;
            // Writable region: cleared on reset, loaded on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ent_q <= '0;
                else if (wr_en && wr_idx == IDX_W'(i))
                    ent_q <= wr_attr;
            end
            assign table_q[i] = ent_q;
        end
    end

    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= RO_LIM) |=> table_q[$past(wr_idx)] == $past(wr_attr));

    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> table_q == '0);
endmodule

// File: rtl/region_attr_lookup.sv
// Lookup path: selects the flag pair of the region that holds a logical
// address, using the top IDX_W address bits. Purely combinational.
module region_attr_lookup
    import region_attr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  attr_t [(1<<IDX_W)-1:0] table_q,
    input  logic  [IDX_W-1:0]      region,
    output logic                   cacheable,
    output logic                   prefetch
);
    // Region select and flag output.
    always_comb begin
        cacheable = table_q[region].cache;
        prefetch  = table_q[region].pref;
    end
endmodule

// File: rtl/region_attr_regfile.sv
// Top level of the region attribute register file. It holds a register port
// with a registered one-cycle response and a combinational lookup port.
// Assumes a 32-bit logical address whose top IDX_W bits select the region.
module region_attr_regfile
    import region_attr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 8,
    parameter int OFF_W    = 12,
    parameter int RO_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              rsp_vld,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              rsp_err,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_cacheable,
    output logic              lk_prefetch
);
    localparam int N_REG = 1 << IDX_W;
    localparam logic [IDX_W-1:0] RO_LIM = IDX_W'(RO_COUNT);

    logic [IDX_W-1:0]   acc_idx;
    logic               acc_bad;
    logic               wr_en;
    attr_t [N_REG-1:0]  table_q;
    logic               unused_bits;

    assign unused_bits = ^{lk_addr[ADDR_W-IDX_W-1:0], reg_wdata};

    region_attr_decode #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_dec (
        .off (reg_off),
        .idx (acc_idx),
        .bad (acc_bad)
    );

    // Only valid writes reach storage; the store ignores fixed entries.
    assign wr_en = reg_req && reg_we && !acc_bad;

    region_attr_store #(.IDX_W(IDX_W), .RO_COUNT(RO_COUNT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (acc_idx),
        .wr_attr (word_to_attr(reg_wdata)),
        .table_q (table_q)
    );

    region_attr_lookup #(.IDX_W(IDX_W)) u_lk (
        .table_q   (table_q),
        .region    (lk_addr[ADDR_W-1 -: IDX_W]),
        .cacheable (lk_cacheable),
        .prefetch  (lk_prefetch)
    );

    // Registered response: valid, error, and read data sampled before the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld   <= reg_req;
            rsp_err   <= reg_req && acc_bad;
            rsp_rdata <= (reg_req && !reg_we && !acc_bad) ?
                         attr_to_word(table_q[acc_idx]) : '0;
        end
    end

    assert_misalign_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && |reg_off[1:0]) |=> (rsp_err && rsp_rdata == '0));

    assert_window_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && |reg_off[OFF_W-1:IDX_W+2]) |=> (rsp_err && rsp_vld));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_rdata & ~((REG_W'(1) << CACHE_POS) | (REG_W'(1) << PREF_POS))) == '0);

    assert_fixed_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we && reg_off[IDX_W+1:2] < RO_LIM) |=> rsp_rdata == '0);

    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> rsp_vld);
endmodule

// File: tb/tb_region_attr_regfile.sv
module tb_region_attr_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic        rsp_vld, rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_cacheable, lk_prefetch;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    bit m_c [256];
    bit m_p [256];
    bit e_vld, e_err;
    logic [31:0] e_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_attr_regfile dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .rsp_vld(rsp_vld),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lk_addr(lk_addr),
        .lk_cacheable(lk_cacheable), .lk_prefetch(lk_prefetch)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Cycle model: updates at each edge, then compares all outputs.
    always @(posedge clk) begin
        int idx;
        bit bad;
        idx = int'(reg_off) >> 2;
        bad = (reg_off[1:0] != 2'b00) || (reg_off >= 12'd1024);
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin m_c[i] = 0; m_p[i] = 0; end
            e_vld = 0; e_err = 0; e_data = '0;
        end else begin
            e_vld  = reg_req;
            e_err  = reg_req && bad;
            e_data = (reg_req && !reg_we && !bad) ?
                     {28'd0, m_p[idx], 2'b00, m_c[idx]} : 32'd0;
            if (reg_req && reg_we && !bad && idx >= 16) begin
                m_c[idx] = reg_wdata[0];
                m_p[idx] = reg_wdata[3];
            end
        end
        #1;
        check(rsp_vld == e_vld, "R10 vld", {31'd0, rsp_vld}, {31'd0, e_vld});
        check(rsp_err == e_err, "R8/R9 err", {31'd0, rsp_err}, {31'd0, e_err});
        check(rsp_rdata == e_data, "R4 rdata", rsp_rdata, e_data);
        check({lk_prefetch, lk_cacheable} == {m_p[lk_addr[31:24]], m_c[lk_addr[31:24]]},
              "R1 lookup", {30'd0, lk_prefetch, lk_cacheable},
              {30'd0, m_p[lk_addr[31:24]], m_c[lk_addr[31:24]]});
    end

    // One register-port access; returns after the response is visible.
    task automatic op(input bit we, input logic [11:0] off, input logic [31:0] wd);
        @(negedge clk);
        reg_req = 1; reg_we = we; reg_off = off; reg_wdata = wd;
        @(posedge clk);
        #2;
        reg_req = 0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        lk_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(rsp_vld == 0 && lk_cacheable == 0 && lk_prefetch == 0, "R7 reset", {31'd0, rsp_vld}, 0);
        @(negedge clk); rst_n = 1;

        op(0, 12'h380, 0);
        check(rsp_rdata == 0, "R7 cleared", rsp_rdata, 0);
        // Write all ones: only bits 0 and 3 survive
        op(1, 12'h380, 32'hFFFF_FFFF);
        look(32'hE012_3456);
        check(lk_cacheable && lk_prefetch, "R6 lookup after write", {30'd0, lk_prefetch, lk_cacheable}, 3);
        op(0, 12'h380, 0);
        check(rsp_rdata == 32'h9, "R3 reserved zero", rsp_rdata, 32'h9);
        op(1, 12'h380, 32'h0000_0008);
        op(0, 12'h380, 0);
        check(rsp_rdata == 32'h8, "R2 prefetch only", rsp_rdata, 32'h8);
        look(32'hE0FF_FFFF);
        check(!lk_cacheable && lk_prefetch, "R2 lookup bits", {30'd0, lk_prefetch, lk_cacheable}, 2);
        // Read-only boundary
        op(1, 12'h03C, 32'h9);
        op(0, 12'h03C, 0);
        check(rsp_rdata == 0, "R5 reg15 fixed", rsp_rdata, 0);
        look(32'h0F00_0000);
        check(!lk_cacheable && !lk_prefetch, "R5 reg15 lookup", {30'd0, lk_prefetch, lk_cacheable}, 0);
        op(1, 12'h040, 32'h1);
        op(0, 12'h040, 0);
        check(rsp_rdata == 1, "R4 reg16 writable", rsp_rdata, 1);
        op(1, 12'h3FC, 32'h9);
        look(32'hFF00_0000);
        check(lk_cacheable && lk_prefetch, "R1 top region", {30'd0, lk_prefetch, lk_cacheable}, 3);
        // Error cases must not write
        op(1, 12'h3FD, 32'h0);
        check(rsp_err && rsp_rdata == 0, "R8 misaligned", {31'd0, rsp_err}, 1);
        op(0, 12'h3FC, 0);
        check(rsp_rdata == 32'h9, "R8 no write", rsp_rdata, 32'h9);
        op(1, 12'h780, 32'h0);
        check(rsp_err, "R9 out of window", {31'd0, rsp_err}, 1);
        op(0, 12'h380, 0);
        check(rsp_rdata == 32'h8, "R9 alias not written", rsp_rdata, 32'h8);

        // Random traffic compared by the model every cycle
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            reg_req   = ($urandom_range(0, 3) != 0);
            reg_we    = $urandom_range(0, 1);
            reg_off   = ($urandom_range(0, 9) == 0) ? 12'($urandom) : {2'b00, 8'($urandom_range(0, 40)), 2'b00};
            reg_wdata = $urandom;
            lk_addr   = ($urandom_range(0, 1) != 0) ? {reg_off[9:2], 24'($urandom)} : $urandom;
        end
        @(negedge clk); reg_req = 0;
        repeat (2) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule